// File: doc/BRIEF.md
# Receive Frame Data Pointer with Width-Scaled Auto-Advance

This block holds the address a host uses to walk through a received frame stored in a buffer. The host sees the buffer only through one data-register window. Each access to that window reads the buffer location named by the pointer. In auto-advance mode, the access then moves the pointer forward by the number of bytes it consumed: one for a byte, two for a word and four for a double word. With auto-advance off, the pointer stays where the host last placed it.

The host sets the pointer and the mode bit with a single register write. It reads both back through the same register image. Software must write the pointer to zero before each block read of a frame from the receive queue. The buffer memory, bus timing and byte-lane swapping lie outside this block.

Top module: `frame_ptr_unit`

## Requirements
- R1: After reset, `addr_out` is 0 and the auto-advance bit (`cfg_rdata[PTR_W]`) is 1.
- R2: A cycle with `acc_stb`=1, `acc_size`=2'b00 (byte), auto-advance on and no `cfg_wr` adds 1 to the pointer at the next clock edge.
- R3: The same with `acc_size`=2'b01 (word) adds 2.
- R4: The same with `acc_size`=2'b10 (double word) adds 4.
- R5: An access with the unused size code 2'b11 leaves the pointer unchanged.
- R6: With auto-advance off (mode bit 0), `acc_stb` leaves the pointer unchanged.
- R7: `cfg_wr` loads the pointer from `cfg_wdata[PTR_W-1:0]` and the mode bit from `cfg_wdata[PTR_W]` at the next edge. When it coincides with an access, the write wins.
- R8: Increments wrap modulo 2^PTR_W. With PTR_W=11, a double-word access at 0x7FF gives 0x003.
- R9: During an access cycle, `addr_out` shows the pointer value before that access's increment.
- R10: `cfg_rdata` always equals {mode bit, pointer}.
- R11: In a cycle with neither `acc_stb` nor `cfg_wr`, the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_stb | input | 1 | Host access to the data window this cycle |
| acc_size | input | 2 | Access width: 00 byte, 01 word, 10 double word, 11 unused |
| cfg_wr | input | 1 | Write of the pointer register |
| cfg_wdata | input | PTR_W+1 | Write value: mode bit on top, pointer below |
| addr_out | output | PTR_W | Current buffer address |
| cfg_rdata | output | PTR_W+1 | Pointer register image: {mode, pointer} |

## Verification
Pointer and mode updates land one clock edge after the cycle that carries the access or the write. `addr_out` and `cfg_rdata` are combinational views of the registers, so an access sees its own address in the same cycle (R9). The bench drives each cycle's inputs just after the falling edge. It checks the current outputs against its model before the rising edge, then advances the model at that edge. This way every result is compared exactly one edge after its cause. Random sequences are mixed with directed wrap, collision and manual-mode cases.

// File: rtl/frame_ptr_pkg.sv
package frame_ptr_pkg;
   typedef enum logic [1:0] {
      ACC_BYTE  = 2'b00,
      ACC_WORD  = 2'b01,
      ACC_DWORD = 2'b10,
      ACC_NONE  = 2'b11
   } acc_size_e;
endpackage

// File: rtl/frame_ptr_step.sv
module frame_ptr_step #(
   parameter int PTR_W     = 11,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic [1:0]       size,
   output logic [PTR_W-1:0] step
);
   import frame_ptr_pkg::*;

   generate
      if (USE_SHIFT) begin : g_shift
         always_comb begin
            if (size == ACC_NONE) step = '0;
            else                  step = PTR_W'(1) << size;
         end
      end else begin : g_case
         always_comb begin
            unique case (size)
               ACC_BYTE:  step = PTR_W'(1);
               ACC_WORD:  step = PTR_W'(2);
               ACC_DWORD: step = PTR_W'(4);
               default:   step = '0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/frame_ptr_reg.sv
module frame_ptr_reg #(
   parameter int PTR_W   = 11,
   parameter int PTR_RST = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             adv,
   input  logic [PTR_W-1:0] step,
   output logic [PTR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= PTR_W'(PTR_RST);
      else if (load) ptr <= load_val;
      else if (adv)  ptr <= ptr + step;
   end
endmodule

// File: rtl/frame_ptr_unit.sv
module frame_ptr_unit #(
   parameter int PTR_W     = 11,
   parameter int PTR_RST   = 0,
   parameter bit AUTO_RST  = 1'b1,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_stb,
   input  logic [1:0]       acc_size,
   input  logic             cfg_wr,
   input  logic [PTR_W:0]   cfg_wdata,
   output logic [PTR_W-1:0] addr_out,
   output logic [PTR_W:0]   cfg_rdata
);
   localparam int PTR_SPAN = 1 << PTR_W;

   generate
      if (PTR_W < 3) begin : g_bad_width
         $error("frame_ptr_unit: PTR_W must be at least 3");
      end
      if (PTR_RST < 0 || PTR_RST >= PTR_SPAN) begin : g_bad_rst
         $error("frame_ptr_unit: PTR_RST outside pointer range");
      end
   endgenerate

   logic             auto_q;
   logic [PTR_W-1:0] step;
   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      auto_q <= AUTO_RST;
      else if (cfg_wr) auto_q <= cfg_wdata[PTR_W];
   end

   frame_ptr_step #(.PTR_W(PTR_W), .USE_SHIFT(USE_SHIFT)) u_step (
      .size (acc_size),
      .step (step)
   );

   frame_ptr_reg #(.PTR_W(PTR_W), .PTR_RST(PTR_RST)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_wr),
      .load_val (cfg_wdata[PTR_W-1:0]),
      .adv      (acc_stb & auto_q),
      .step     (step),
      .ptr      (ptr)
   );

   assign addr_out  = ptr;
   assign cfg_rdata = {auto_q, ptr};
endmodule

// File: rtl/frame_ptr_unit_chk.sv
module frame_ptr_unit_chk #(
   parameter int PTR_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_stb,
   input logic [1:0]       acc_size,
   input logic             cfg_wr,
   input logic [PTR_W:0]   cfg_wdata,
   input logic [PTR_W-1:0] addr_out,
   input logic [PTR_W:0]   cfg_rdata
);
   logic mode;
   assign mode = cfg_rdata[PTR_W];

   assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (addr_out == '0 && mode));

   assert_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && mode && !cfg_wr && acc_size == 2'b00)
      |=> addr_out == PTR_W'($past(addr_out) + PTR_W'(1)));

   assert_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && mode && !cfg_wr && acc_size == 2'b01)
      |=> addr_out == PTR_W'($past(addr_out) + PTR_W'(2)));

   assert_dword_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && mode && !cfg_wr && acc_size == 2'b10)
      |=> addr_out == PTR_W'($past(addr_out) + PTR_W'(4)));

   assert_unused_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !cfg_wr && acc_size == 2'b11) |=> $stable(addr_out));

   assert_manual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !mode && !cfg_wr) |=> $stable(addr_out));

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_stb && !cfg_wr) |=> ($stable(addr_out) && $stable(mode)));
endmodule

bind frame_ptr_unit frame_ptr_unit_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_stb   (acc_stb),
   .acc_size  (acc_size),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .addr_out  (addr_out),
   .cfg_rdata (cfg_rdata)
);

// File: tb/frame_ptr_unit_bench.sv
`timescale 1ns/1ps
module frame_ptr_unit_bench;
   localparam int PTR_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_stb = 1'b0;
   logic [1:0]       acc_size = 2'b00;
   logic             cfg_wr = 1'b0;
   logic [PTR_W:0]   cfg_wdata = '0;
   logic [PTR_W-1:0] addr_out;
   logic [PTR_W:0]   cfg_rdata;

   int n_run = 0;
   int n_fail = 0;
   logic [PTR_W-1:0] exp_ptr = '0;
   logic             exp_mode = 1'b1;
   string            tag = "R1";
   bit               done = 1'b0;

   always #4 clk = ~clk;

   frame_ptr_unit #(.PTR_W(PTR_W)) u_frame_ptr_unit (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_size(acc_size),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .addr_out(addr_out), .cfg_rdata(cfg_rdata)
   );

   function automatic logic [PTR_W-1:0] next_ptr(
      input logic [PTR_W-1:0] p, input logic m, input logic stb,
      input logic [1:0] sz, input logic wr, input logic [PTR_W:0] wd);
      logic [PTR_W-1:0] inc;
      case (sz)
         2'b00:   inc = 1;
         2'b01:   inc = 2;
         2'b10:   inc = 4;
         default: inc = 0;
      endcase
      if (wr)            return wd[PTR_W-1:0];
      else if (stb && m) return p + inc;
      else               return p;
   endfunction

   function automatic string pick_tag(input logic m, input logic stb,
      input logic [1:0] sz, input logic wr);
      if (wr)        return "R7";
      if (!stb)      return "R11";
      if (!m)        return "R6";
      case (sz)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check_outputs();
      n_run++;
      if (addr_out !== exp_ptr) begin
         n_fail++;
         $display("FAIL %s addr_out actual=%h expected=%h", tag, addr_out, exp_ptr);
      end
      n_run++;
      if (cfg_rdata !== {exp_mode, exp_ptr}) begin
         n_fail++;
         $display("FAIL R10 cfg_rdata actual=%h expected=%h", cfg_rdata, {exp_mode, exp_ptr});
      end
   endtask

   // One cycle: check state left by the previous edge, drive, check R9, advance model.
   task automatic cycle(input logic stb, input logic [1:0] sz,
                        input logic wr, input logic [PTR_W:0] wd);
      @(negedge clk);
      check_outputs();
      acc_stb = stb; acc_size = sz; cfg_wr = wr; cfg_wdata = wd;
      #1;
      if (stb) begin
         n_run++;
         if (addr_out !== exp_ptr) begin
            n_fail++;
            $display("FAIL R9 addr during access actual=%h expected=%h", addr_out, exp_ptr);
         end
      end
      @(posedge clk);
      exp_ptr  = next_ptr(exp_ptr, exp_mode, stb, sz, wr, wd);
      if (wr) exp_mode = wd[PTR_W];
      tag = pick_tag(exp_mode, stb, sz, wr);
      if (wr) tag = "R7";
   endtask

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd20251);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      check_outputs();

      // directed: each size in auto mode
      cycle(1'b1, 2'b00, 1'b0, '0);
      cycle(1'b1, 2'b01, 1'b0, '0);
      cycle(1'b1, 2'b10, 1'b0, '0);
      cycle(1'b1, 2'b11, 1'b0, '0);
      cycle(1'b0, 2'b10, 1'b0, '0);
      // R8 wrap: load 0x7FF auto, dword -> 0x003
      cycle(1'b0, 2'b00, 1'b1, {1'b1, 11'h7FF});
      cycle(1'b1, 2'b10, 1'b0, '0);
      cycle(1'b1, 2'b01, 1'b1, {1'b1, 11'h7FE});
      cycle(1'b1, 2'b01, 1'b0, '0);
      // R7 collision: write wins
      cycle(1'b1, 2'b10, 1'b1, {1'b1, 11'h123});
      // R6 manual mode
      cycle(1'b0, 2'b00, 1'b1, {1'b0, 11'h040});
      cycle(1'b1, 2'b00, 1'b0, '0);
      cycle(1'b1, 2'b10, 1'b0, '0);
      cycle(1'b0, 2'b00, 1'b1, {1'b1, 11'h000});

      for (int i = 0; i < 600; i++) begin
         logic        stb, wr;
         logic [1:0]  sz;
         logic [PTR_W:0] wd;
         stb = ($urandom % 4) != 0;
         sz  = 2'($urandom);
         wr  = ($urandom % 12) == 0;
         wd  = (PTR_W+1)'($urandom);
         if (($urandom % 3) != 0) wd[PTR_W] = 1'b1;
         cycle(stb, sz, wr, wd);
      end
      cycle(1'b0, 2'b00, 1'b0, '0);
      @(negedge clk);
      check_outputs();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule